// File: doc/BRIEF.md
# Return-to-Zero Serial Word Transmitter

This block takes 32-bit words from a 16-bit host bus and sends them as return-to-zero serial data. The host writes each word in two halves. A low-half strobe captures bits 16..1, and a following high-half strobe supplies bits 32..17. The high-half strobe completes the word and pushes it into an eight-entry queue.

While the transmit enable is high, the block takes words from the queue. It shifts each one out least significant bit first on two lines. One line pulses for every 1 bit and the other pulses for every 0 bit. Every word is followed by four null bit periods.

The bit period is the master clock divided by 10 or by 80, picked at run time. The divided clock is also brought out. A ready flag tells the host that the queue is empty and the line has gone quiet. As an option, the top bit of each word is replaced by an odd-parity bit when the word is sent.

Top module: `rz_word_tx`

## Requirements
- R1: A pulse on `load_lo_i` stores `data_i` as word bits [15:0]. A later pulse on `load_hi_i` adds `data_i` as word bits [31:16] and pushes the word. A `load_hi_i` pulse with no stored low half since the last push is ignored and pushes nothing.
- R2: The queue holds up to 8 words. Words are transmitted in the order they were pushed.
- R3: A push while 8 words are queued is ignored. The queued words are not changed and are all sent unaltered.
- R4: With `rate_slow_i`=0 a bit period is 10 clocks; with `rate_slow_i`=1 it is 80 clocks. `bit_clk_o` is high for the first half of each period and low for the second half.
- R5: Bits go out as word[0] first through word[31]. A 1 bit drives `one_o` high and a 0 bit drives `zero_o` high, each for the first half of the bit period only. Both lines are low for the second half, and they are never high together.
- R6: Between back-to-back words the line is null (both outputs low) for exactly 4 full bit periods, in addition to the low half of the last bit. The null time is never shorter than that.
- R7: A word starts only at a bit boundary where `tx_en_i` is high. While `tx_en_i` is low, queued words stay in the queue and both outputs stay low.
- R8: With `parity_en_i`=1 at the moment a word leaves the queue, bit 31 is sent as the odd parity of bits [30:0], so the 32 sent bits hold an odd number of ones. With `parity_en_i`=0 the word is sent as loaded.
- R9: `ready_o` is 1 after reset and goes to 0 in the cycle after an accepted push. It returns to 1 only when the queue is empty and the last word's null gap has ended.
- R10: While `rst_ni` is low the queue is emptied and any stored low half is dropped. `one_o` and `zero_o` are 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Host data half-word |
| load_lo_i | input | 1 | Strobe capturing word bits [15:0] |
| load_hi_i | input | 1 | Strobe capturing bits [31:16] and pushing the word |
| tx_en_i | input | 1 | Transmit enable |
| rate_slow_i | input | 1 | 0: divide by 10, 1: divide by 80 |
| parity_en_i | input | 1 | Replace bit 31 with odd parity |
| ready_o | output | 1 | Queue empty and line idle |
| one_o | output | 1 | RZ pulse line for 1 bits |
| zero_o | output | 1 | RZ pulse line for 0 bits |
| bit_clk_o | output | 1 | Divided bit clock |

## Verification
A host push can fall in the same clock cycle as the serializer's pop at a word boundary. The queue must then move one entry in and one out without losing or repeating a word. The bench provokes this by issuing random loads with random spacing while words are streaming at the fast rate, and it mixes in stray high-half strobes. Each received word is decoded from the two pulse lines and compared in order against the list of accepted pushes, including the parity rewrite. The queue depth is kept below full, so every push in this phase is known to be accepted.

// File: rtl/rz_word_tx_pkg.sv
package rz_word_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/rz_baud_gen.sv
module rz_baud_gen #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o,
  output logic first_half_o
);
  localparam int CNT_W = $clog2(DIV_SLOW);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(DIV_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(DIV_SLOW - 1);
  localparam logic [CNT_W-1:0] HALF_F = CNT_W'(DIV_FAST / 2);
  localparam logic [CNT_W-1:0] HALF_S = CNT_W'(DIV_SLOW / 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_sel, half_sel;

  assign last_sel     = slow_i ? LAST_S : LAST_F;
  assign half_sel     = slow_i ? HALF_S : HALF_F;
  // >= so a switch to the fast rate mid-period wraps at once
  assign tick_o       = (cnt_q >= last_sel);
  assign first_half_o = (cnt_q < half_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= LAST_S));
endmodule

// File: rtl/rz_half_loader.sv
module rz_half_loader #(
  parameter int HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HALF_W-1:0]   data_i,
  input  logic                load_lo_i,
  input  logic                load_hi_i,
  output logic                push_o,
  output logic [2*HALF_W-1:0] word_o
);
  logic [HALF_W-1:0] lo_q;
  logic              lo_vld_q;

  assign push_o = load_hi_i && lo_vld_q;
  assign word_o = {data_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      lo_vld_q <= 1'b0;
    end else begin
      if (load_lo_i) begin
        lo_q     <= data_i;
        lo_vld_q <= 1'b1;
      end else if (load_hi_i) begin
        lo_vld_q <= 1'b0;
      end
    end
  end

  // R1
  hi_consumes_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_hi_i && !load_lo_i) |=> !push_o);
endmodule

// File: rtl/rz_word_fifo.sv
module rz_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en, rd_en;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (rd_en) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_q)));
  // R2
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= CNT_W'(DEPTH)));
endmodule

// File: rtl/rz_serializer.sv
module rz_serializer
  import rz_word_tx_pkg::*;
#(
  parameter int W        = 32,
  parameter int GAP_BITS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         first_half_i,
  input  logic         tx_en_i,
  input  logic         parity_en_i,
  input  logic         empty_i,
  input  logic [W-1:0] word_i,
  output logic         pop_o,
  output logic         one_o,
  output logic         zero_o,
  output logic         idle_o
);
  localparam int IDX_W = $clog2(W);
  localparam int GAP_W = $clog2(GAP_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_BITS - 1);

  tx_state_e        state_q;
  logic [W-1:0]     sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [GAP_W-1:0] gap_q;
  logic [W-1:0]     load_word;
  logic             at_boundary;

  assign load_word   = parity_en_i ? {~^word_i[W-2:0], word_i[W-2:0]} : word_i;
  assign at_boundary = (state_q == ST_IDLE) || (state_q == ST_GAP && gap_q == GAP_LAST);
  assign pop_o       = tick_i && tx_en_i && !empty_i && at_boundary;
  assign idle_o      = (state_q == ST_IDLE);
  assign one_o       = (state_q == ST_DATA) && sh_q[0] && first_half_i;
  assign zero_o      = (state_q == ST_DATA) && !sh_q[0] && first_half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
    end else if (pop_o) begin
      state_q <= ST_DATA;
      sh_q    <= load_word;
      idx_q   <= '0;
    end else if (tick_i) begin
      case (state_q)
        ST_DATA: begin
          if (idx_q == IDX_LAST) begin
            state_q <= ST_GAP;
            gap_q   <= '0;
          end else begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) state_q <= ST_IDLE;
          else                   gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  hold_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !tx_en_i) |=> (state_q == ST_IDLE));
  // R6
  gap_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && tick_i && gap_q != GAP_LAST) |=> (state_q == ST_GAP));
  // R5
  lines_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({one_o, zero_o}));
  // R5
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !tick_i) |=> $stable(sh_q));
endmodule

// File: rtl/rz_word_tx.sv
module rz_word_tx #(
  parameter int HALF_W   = 16,
  parameter int DEPTH    = 8,
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  parameter int GAP_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] data_i,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic              tx_en_i,
  input  logic              rate_slow_i,
  input  logic              parity_en_i,
  output logic              ready_o,
  output logic              one_o,
  output logic              zero_o,
  output logic              bit_clk_o
);
  localparam int W = 2 * HALF_W;

  logic         tick, first_half, push, pop, empty, full, idle;
  logic [W-1:0] in_word, head_word;

  rz_baud_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_i(rate_slow_i),
    .tick_o(tick), .first_half_o(first_half)
  );

  rz_half_loader #(.HALF_W(HALF_W)) u_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .load_lo_i(load_lo_i), .load_hi_i(load_hi_i),
    .push_o(push), .word_o(in_word)
  );

  rz_word_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .din_i(in_word),
    .pop_i(pop), .dout_o(head_word), .empty_o(empty), .full_o(full)
  );

  rz_serializer #(.W(W), .GAP_BITS(GAP_BITS)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .first_half_i(first_half),
    .tx_en_i(tx_en_i), .parity_en_i(parity_en_i), .empty_i(empty),
    .word_i(head_word), .pop_o(pop), .one_o(one_o), .zero_o(zero_o),
    .idle_o(idle)
  );

  assign ready_o   = empty && idle;
  assign bit_clk_o = first_half;

  // R9
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !full) |=> !ready_o);
endmodule

// File: tb/sim_rz_word_tx.sv
module sim_rz_word_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data = '0;
  logic        s_lo = 1'b0, s_hi = 1'b0, tx_en = 1'b0, slow = 1'b0, par_en = 1'b0;
  logic        ready, one, zero, bclk;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int div = 10;
  logic [31:0] exp_mem [0:255];
  int exp_wr = 0;
  int words_rx = 0;
  int last_gap = 0;

  always #5 clk = ~clk;

  rz_word_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .load_lo_i(s_lo),
    .load_hi_i(s_hi), .tx_en_i(tx_en), .rate_slow_i(slow),
    .parity_en_i(par_en), .ready_o(ready), .one_o(one), .zero_o(zero),
    .bit_clk_o(bclk)
  );

  function automatic logic [31:0] sent_form(input logic [31:0] w, input logic p);
    return p ? {~^w[30:0], w[30:0]} : w;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line monitor: decodes RZ pulses into words
  logic        prev_act;
  int          low_run, high_run, bitn;
  logic [31:0] rxw;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_act = 1'b0; low_run = 100000; high_run = 0; bitn = 0; rxw = '0;
    end else begin
      if (one && zero) begin
        mon_checks++; mon_errors++;
        $display("FAIL R5 both lines high actual=3 expected=1or2");
      end
      if ((one || zero) && !prev_act) begin
        mon_checks++;
        if (bitn == 0) begin
          last_gap = low_run;
          if (low_run < (div - div/2) + 4*div) begin
            mon_errors++;
            $display("FAIL R6 null gap actual=%0d expected>=%0d", low_run, (div - div/2) + 4*div);
          end
        end else if (low_run != div - div/2) begin
          mon_errors++;
          $display("FAIL R5 low half actual=%0d expected=%0d", low_run, div - div/2);
        end
        rxw[bitn] = one;
        bitn++;
        if (bitn == 32) begin
          mon_checks++;
          if (words_rx >= exp_wr) begin
            mon_errors++;
            $display("FAIL R2 unexpected word actual=%0h expected=none", rxw);
          end else if (rxw != exp_mem[words_rx]) begin
            mon_errors++;
            $display("FAIL R2 word %0d actual=%0h expected=%0h", words_rx, rxw, exp_mem[words_rx]);
          end
          words_rx++;
          bitn = 0;
        end
        low_run = 0; high_run = 1;
      end else if (one || zero) begin
        high_run++;
      end else begin
        if (prev_act) begin
          mon_checks++;
          if (high_run != div/2) begin
            mon_errors++;
            $display("FAIL R5 pulse width actual=%0d expected=%0d", high_run, div/2);
          end
        end
        low_run++;
      end
      prev_act = one || zero;
    end
  end

  task automatic load_word(input logic [31:0] w, input bit accept);
    @(posedge clk); #1 data = w[15:0]; s_lo = 1'b1;
    @(posedge clk); #1 s_lo = 1'b0; data = w[31:16]; s_hi = 1'b1;
    @(posedge clk); #1 s_hi = 1'b0;
    if (accept) begin
      exp_mem[exp_wr] = sent_form(w, par_en);
      exp_wr++;
    end
  endtask

  task automatic measure_bclk(input string tag);
    int hi = 0, lo = 0;
    @(negedge clk); while (bclk) @(negedge clk);
    while (!bclk) @(negedge clk);
    while (bclk) begin hi++; @(negedge clk); end
    while (!bclk) begin lo++; @(negedge clk); end
    chk(hi == div/2, tag, hi, div/2);
    chk(lo == div - div/2, tag, lo, div - div/2);
  endtask

  task automatic wait_drained();
    while (words_rx < exp_wr) @(negedge clk);
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(ready == 1'b1, "R10 ready in reset", ready, 1);
    chk(one == 1'b0 && zero == 1'b0, "R10 lines in reset", {one, zero}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R9 ready after reset", ready, 1);

    // R1 stray high strobe pushes nothing
    @(posedge clk); #1 data = 16'hBEEF; s_hi = 1'b1;
    @(posedge clk); #1 s_hi = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 lone high strobe ignored", ready, 1);

    // R4 fast bit clock
    div = 10;
    measure_bclk("R4 fast bit clock");

    // R2/R3 fill queue with transmit disabled, ninth word dropped
    for (int i = 0; i < 9; i++) load_word($urandom(), i < 8);
    @(negedge clk);
    chk(ready == 1'b0, "R9 ready low after push", ready, 0);
    repeat (2000) @(negedge clk);
    chk(words_rx == 0, "R7 nothing sent while disabled", words_rx, 0);
    chk(one == 1'b0 && zero == 1'b0, "R7 lines idle while disabled", {one, zero}, 0);
    #1 tx_en = 1'b1;
    while (words_rx < 8) @(negedge clk);
    chk(ready == 1'b0, "R9 ready low during final gap", ready, 0);
    chk(last_gap == (div - div/2) + 4*div, "R6 back-to-back gap", last_gap, (div - div/2) + 4*div);
    while (!ready) @(negedge clk);
    repeat (500) @(negedge clk);
    chk(words_rx == 8, "R3 ninth word dropped", words_rx, 8);
    chk(ready == 1'b1, "R9 ready after drain", ready, 1);

    // R8 parity with directed words: even and odd ones below bit 31
    #1 par_en = 1'b1;
    load_word(32'h0000_0003, 1'b1);
    load_word(32'h8000_0001, 1'b1);
    load_word(32'h7FFF_FFFF, 1'b1);
    wait_drained();
    chk(words_rx == exp_wr, "R8 parity words received", words_rx, exp_wr);
    chk(exp_mem[exp_wr-3][31] == 1'b1, "R8 parity bit set for even ones", exp_mem[exp_wr-3][31], 1);

    // R4 slow rate
    #1 slow = 1'b1; div = 80; par_en = 1'b0;
    repeat (100) @(negedge clk);
    measure_bclk("R4 slow bit clock");
    load_word(32'hA5A5_0F0F, 1'b1);
    load_word(32'h1234_5678, 1'b1);
    wait_drained();
    chk(last_gap == (div - div/2) + 4*div, "R6 slow gap", last_gap, (div - div/2) + 4*div);
    chk(words_rx == exp_wr, "R4 slow words received", words_rx, exp_wr);

    // R2 random loads racing the serializer at the fast rate
    #1 slow = 1'b0; par_en = 1'b1;
    repeat (100) @(negedge clk);
    div = 10;
    for (int n = 0; n < 24; ) begin
      repeat ($urandom_range(1, 120)) @(posedge clk);
      if ($urandom_range(0, 5) == 0) begin
        @(posedge clk); #1 data = 16'h5555; s_hi = 1'b1;
        @(posedge clk); #1 s_hi = 1'b0;
      end else if (exp_wr - words_rx < 7) begin
        load_word($urandom(), 1'b1);
        n++;
      end
    end
    wait_drained();
    chk(words_rx == exp_wr, "R2 random stream count", words_rx, exp_wr);
    chk(ready == 1'b1, "R9 ready after random stream", ready, 1);

    // R7 disable holds queued words
    #1 tx_en = 1'b0;
    repeat (50) @(negedge clk);
    load_word(32'hCAFE_F00D, 1'b1);
    repeat (1000) @(negedge clk);
    chk(words_rx == exp_wr - 1, "R7 held while disabled", words_rx, exp_wr - 1);
    #1 tx_en = 1'b1;
    wait_drained();
    chk(words_rx == exp_wr, "R7 sent after enable", words_rx, exp_wr);

    $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    $finish;
  end
endmodule